// File: doc/BRIEF.md
# Programmable CRT Timing Generator

This block produces the raster timing for a cathode-ray display. It advances once per character clock. A horizontal character counter and a vertical row counter run against a bank of byte-wide timing registers. From them the block derives horizontal and vertical sync, horizontal and vertical blanking, a display-enable strobe, and the start address in display memory of the current scan line.

Software programs the bank through a two-step port. An index strobe selects a register, and a data strobe writes the selected register. The selected register can be read back on a separate read bus. A separate strobe loads the sync polarity bits.

Several ten-bit vertical values keep their two high bits in a shared overflow register. Blanking-end and retrace-end values are short, so they are matched against only the low bits of the counters. A protect bit locks the horizontal registers and the overflow register until software clears it.

Top module: `crt_timing_gen`

## Requirements
- R1: While rst_ni is low, every sync, blank and enable output is 0, line_addr_o is 0, and all registers are cleared.
- R2: A scan line lasts (register 0x00 + 5) character clocks.
- R3: display-enable is high for (register 0x01 + 1) characters at the start of each line, and only on rows 0 up to the ten-bit display-end value.
- R4: Horizontal blank starts when the counter equals register 0x02, compared on all 8 bits. It ends when the counter's low 6 bits equal the 6-bit value formed from register 0x05 bit 7 (bit 5) and register 0x03 bits 4:0 (bits 4:0).
- R5: Horizontal sync starts when the counter equals register 0x04, compared on all 8 bits. It ends when the counter's low 5 bits equal register 0x05 bits 4:0.
- R6: A frame lasts (vertical total + 2) rows. Vertical total takes bits 7:0 from register 0x06, bit 8 from register 0x07 bit 0, and bit 9 from register 0x07 bit 5.
- R7: Vertical sync starts on the row equal to the ten-bit value formed from register 0x10, register 0x07 bit 2 (bit 8) and register 0x07 bit 7 (bit 9). It ends on the row whose low 4 bits equal register 0x11 bits 3:0.
- R8: Vertical blank starts on the row equal to the ten-bit value formed from register 0x15, register 0x07 bit 3 (bit 8) and register 0x09 bit 5 (bit 9). It ends on the row whose low 8 bits equal register 0x16.
- R9: The display-end row takes bits 7:0 from register 0x12, bit 8 from register 0x07 bit 1, and bit 9 from register 0x07 bit 6.
- R10: Misc bit 6 inverts hsync_o and misc bit 7 inverts vsync_o. A 1 selects active-low.
- R11: When register 0x11 bit 7 is set, data writes to indices 0x00 through 0x07 are dropped. Register 0x11 stays writable, so the lock can be cleared by a read-modify-write.
- R12: rdata_o shows the register at the current index one clock after the index changes, and reads 0 for indices beyond the bank.
- R13: line_addr_o advances by 8 × register 0x13 after every (register 0x09 bits 4:0 + 1) rows, and returns to 0 when a frame wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_we_i | input | 1 | Load the index register from wdata_i |
| data_we_i | input | 1 | Write wdata_i to the register selected by the index |
| misc_we_i | input | 1 | Load the polarity bits from wdata_i[7:6] |
| wdata_i | input | 8 | Write data shared by all three strobes |
| rdata_o | output | 8 | Registered read-back of the selected register |
| hsync_o | output | 1 | Horizontal sync, with the programmed polarity |
| vsync_o | output | 1 | Vertical sync, with the programmed polarity |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| de_o | output | 1 | Display enable |
| line_addr_o | output | ADDR_W | Memory start address of the current scan line |

## Verification
Every horizontal output follows its counter condition by exactly one character clock. Vertical outputs change one clock after the row counter steps, and line_addr_o changes on the same edge as the row counter. rdata_o is valid two clocks after the index strobe.

A fixed one-clock lag does not change widths or periods. The bench therefore checks timing as the widths and periods of pulses sampled on falling edges, and checks display-enable by counting over a window exactly one frame long.

line_addr_o is sampled at whole multiples of the line length after the frame-wrap return to 0 is seen. The bench lets more than a frame pass after any reprogramming of a vertical field before it judges a pulse that can never start.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int REG_CNT  = 24;
  localparam int IDX_W    = $clog2(REG_CNT);
  localparam int VVAL_W   = 10;
  localparam int PROT_TOP = 7;

  localparam int IX_HTOT = 'h00;
  localparam int IX_HDE  = 'h01;
  localparam int IX_HBS  = 'h02;
  localparam int IX_HBE  = 'h03;
  localparam int IX_HSS  = 'h04;
  localparam int IX_HSE  = 'h05;
  localparam int IX_VTOT = 'h06;
  localparam int IX_OVF  = 'h07;
  localparam int IX_SCAN = 'h09;
  localparam int IX_VSS  = 'h10;
  localparam int IX_VEND = 'h11;
  localparam int IX_VDE  = 'h12;
  localparam int IX_OFS  = 'h13;
  localparam int IX_VBS  = 'h15;
  localparam int IX_VBE  = 'h16;

  localparam int HTOT_ADJ = 4;
  localparam int VTOT_ADJ = 1;

  typedef struct packed {
    logic [7:0]        htotal;
    logic [7:0]        hde_end;
    logic [7:0]        hbs;
    logic [5:0]        hbe;
    logic [7:0]        hss;
    logic [4:0]        hse;
    logic [VVAL_W-1:0] vtotal;
    logic [VVAL_W-1:0] vde_end;
    logic [VVAL_W-1:0] vss;
    logic [3:0]        vse;
    logic [VVAL_W-1:0] vbs;
    logic [7:0]        vbe;
    logic [4:0]        max_scan;
    logic [7:0]        offset;
    logic              hpol;
    logic              vpol;
  } crt_cfg_t;
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile
  import crt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_we_i,
  input  logic       data_we_i,
  input  logic       misc_we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] idx_o,
  output logic       prot_o,
  output crt_cfg_t   cfg_o
);
  logic [7:0] regs_q [REG_CNT];
  logic [7:0] idx_q;
  logic [7:0] rdata_q;
  logic [1:0] pol_q;
  logic       in_range, locked;

  assign in_range = idx_q < 8'(REG_CNT);
  assign prot_o   = regs_q[IX_VEND][7];
  assign locked   = prot_o && (idx_q <= 8'(PROT_TOP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_CNT; i++) regs_q[i] <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
      pol_q   <= '0;
    end else begin
      if (idx_we_i) idx_q <= wdata_i;
      if (misc_we_i) pol_q <= wdata_i[7:6];
      if (data_we_i && in_range && !locked) regs_q[idx_q[IDX_W-1:0]] <= wdata_i;
      rdata_q <= in_range ? regs_q[idx_q[IDX_W-1:0]] : 8'h00;
    end
  end

  assign rdata_o = rdata_q;
  assign idx_o   = idx_q;

  // scatter the split fields back together
  always_comb begin
    cfg_o.htotal   = regs_q[IX_HTOT];
    cfg_o.hde_end  = regs_q[IX_HDE];
    cfg_o.hbs      = regs_q[IX_HBS];
    cfg_o.hbe      = {regs_q[IX_HSE][7], regs_q[IX_HBE][4:0]};
    cfg_o.hss      = regs_q[IX_HSS];
    cfg_o.hse      = regs_q[IX_HSE][4:0];
    cfg_o.vtotal   = {regs_q[IX_OVF][5], regs_q[IX_OVF][0], regs_q[IX_VTOT]};
    cfg_o.vde_end  = {regs_q[IX_OVF][6], regs_q[IX_OVF][1], regs_q[IX_VDE]};
    cfg_o.vss      = {regs_q[IX_OVF][7], regs_q[IX_OVF][2], regs_q[IX_VSS]};
    cfg_o.vse      = regs_q[IX_VEND][3:0];
    cfg_o.vbs      = {regs_q[IX_SCAN][5], regs_q[IX_OVF][3], regs_q[IX_VBS]};
    cfg_o.vbe      = regs_q[IX_VBE];
    cfg_o.max_scan = regs_q[IX_SCAN][4:0];
    cfg_o.offset   = regs_q[IX_OFS];
    cfg_o.hpol     = pol_q[0];
    cfg_o.vpol     = pol_q[1];
  end
endmodule

// File: rtl/crt_hgen.sv
module crt_hgen #(
  parameter int HCNT_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        htotal_i,
  input  logic [7:0]        hde_end_i,
  input  logic [7:0]        hbs_i,
  input  logic [5:0]        hbe_i,
  input  logic [7:0]        hss_i,
  input  logic [4:0]        hse_i,
  input  logic              hpol_i,
  output logic [HCNT_W-1:0] hcnt_o,
  output logic              line_end_o,
  output logic              h_disp_o,
  output logic              hblank_o,
  output logic              hsync_o
);
  logic [HCNT_W-1:0] hcnt_q;
  logic hb_q, hs_act_q, hs_q;
  logic hb_nxt, hs_nxt;

  // >= so a shortened total never strands the counter
  assign line_end_o = hcnt_q >= (HCNT_W'(htotal_i) + HCNT_W'(crt_pkg::HTOT_ADJ));
  assign h_disp_o   = hcnt_q <= HCNT_W'(hde_end_i);

  assign hb_nxt = (hcnt_q == HCNT_W'(hbs_i)) | (hb_q & (hcnt_q[5:0] != hbe_i));
  assign hs_nxt = (hcnt_q == HCNT_W'(hss_i)) | (hs_act_q & (hcnt_q[4:0] != hse_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q   <= '0;
      hb_q     <= 1'b0;
      hs_act_q <= 1'b0;
      hs_q     <= 1'b0;
    end else begin
      hcnt_q   <= line_end_o ? '0 : hcnt_q + 1'b1;
      hb_q     <= hb_nxt;
      hs_act_q <= hs_nxt;
      hs_q     <= hs_nxt ^ hpol_i;
    end
  end

  assign hcnt_o   = hcnt_q;
  assign hblank_o = hb_q;
  assign hsync_o  = hs_q;
endmodule

// File: rtl/crt_vgen.sv
module crt_vgen #(
  parameter int VCNT_W = 11,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_end_i,
  input  logic              h_disp_i,
  input  logic [9:0]        vtotal_i,
  input  logic [9:0]        vde_end_i,
  input  logic [9:0]        vss_i,
  input  logic [3:0]        vse_i,
  input  logic [9:0]        vbs_i,
  input  logic [7:0]        vbe_i,
  input  logic [4:0]        max_scan_i,
  input  logic [7:0]        offset_i,
  input  logic              vpol_i,
  output logic [VCNT_W-1:0] vcnt_o,
  output logic              frame_end_o,
  output logic              vblank_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [ADDR_W-1:0] line_addr_o
);
  localparam int STEP_W = 11;

  logic [VCNT_W-1:0] vcnt_q;
  logic [4:0]        scan_q;
  logic [ADDR_W-1:0] addr_q;
  logic vb_q, vs_act_q, vs_q, de_q;
  logic vb_nxt, vs_nxt, v_disp;
  logic [ADDR_W-1:0] step;

  assign frame_end_o = line_end_i &&
                       (vcnt_q >= (VCNT_W'(vtotal_i) + VCNT_W'(crt_pkg::VTOT_ADJ)));
  assign v_disp = vcnt_q <= VCNT_W'(vde_end_i);
  assign step   = ADDR_W'(STEP_W'({offset_i, 3'b000}));

  assign vb_nxt = (vcnt_q == VCNT_W'(vbs_i)) | (vb_q & (vcnt_q[7:0] != vbe_i));
  assign vs_nxt = (vcnt_q == VCNT_W'(vss_i)) | (vs_act_q & (vcnt_q[3:0] != vse_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q   <= '0;
      scan_q   <= '0;
      addr_q   <= '0;
      vb_q     <= 1'b0;
      vs_act_q <= 1'b0;
      vs_q     <= 1'b0;
      de_q     <= 1'b0;
    end else begin
      if (frame_end_o) begin
        vcnt_q <= '0;
        scan_q <= '0;
        addr_q <= '0;
      end else if (line_end_i) begin
        vcnt_q <= vcnt_q + 1'b1;
        if (scan_q >= max_scan_i) begin
          scan_q <= '0;
          addr_q <= addr_q + step;
        end else begin
          scan_q <= scan_q + 1'b1;
        end
      end
      vb_q     <= vb_nxt;
      vs_act_q <= vs_nxt;
      vs_q     <= vs_nxt ^ vpol_i;
      de_q     <= h_disp_i & v_disp;
    end
  end

  assign vcnt_o      = vcnt_q;
  assign vblank_o    = vb_q;
  assign vsync_o     = vs_q;
  assign de_o        = de_q;
  assign line_addr_o = addr_q;
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_pkg::*;
#(
  parameter int HCNT_W = 9,
  parameter int VCNT_W = 11,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              data_we_i,
  input  logic              misc_we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              de_o,
  output logic [ADDR_W-1:0] line_addr_o
);
  crt_cfg_t          cfg;
  logic [7:0]        idx;
  logic              prot;
  logic [HCNT_W-1:0] hcnt;
  logic [VCNT_W-1:0] vcnt;
  logic              line_end, frame_end, h_disp;

  crt_regfile u_regs (
    .clk_i, .rst_ni, .idx_we_i, .data_we_i, .misc_we_i, .wdata_i,
    .rdata_o, .idx_o(idx), .prot_o(prot), .cfg_o(cfg)
  );

  crt_hgen #(.HCNT_W(HCNT_W)) u_hgen (
    .clk_i, .rst_ni,
    .htotal_i(cfg.htotal), .hde_end_i(cfg.hde_end), .hbs_i(cfg.hbs),
    .hbe_i(cfg.hbe), .hss_i(cfg.hss), .hse_i(cfg.hse), .hpol_i(cfg.hpol),
    .hcnt_o(hcnt), .line_end_o(line_end), .h_disp_o(h_disp),
    .hblank_o, .hsync_o
  );

  crt_vgen #(.VCNT_W(VCNT_W), .ADDR_W(ADDR_W)) u_vgen (
    .clk_i, .rst_ni, .line_end_i(line_end), .h_disp_i(h_disp),
    .vtotal_i(cfg.vtotal), .vde_end_i(cfg.vde_end), .vss_i(cfg.vss),
    .vse_i(cfg.vse), .vbs_i(cfg.vbs), .vbe_i(cfg.vbe),
    .max_scan_i(cfg.max_scan), .offset_i(cfg.offset), .vpol_i(cfg.vpol),
    .vcnt_o(vcnt), .frame_end_o(frame_end), .vblank_o, .vsync_o, .de_o,
    .line_addr_o
  );
endmodule

// File: rtl/crt_timing_gen_chk.sv
module crt_timing_gen_chk #(
  parameter int HCNT_W = 9,
  parameter int VCNT_W = 11,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [HCNT_W-1:0] hcnt,
  input logic [VCNT_W-1:0] vcnt,
  input logic              line_end,
  input logic              frame_end,
  input logic [7:0]        hss,
  input logic              hpol,
  input logic [7:0]        htotal,
  input logic [9:0]        vtotal,
  input logic              data_we_i,
  input logic [7:0]        idx,
  input logic              prot,
  input logic              hsync_o,
  input logic [ADDR_W-1:0] line_addr_o
);
  // R5
  hs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hsync_o) && !$past(hpol) && !$past(hpol, 2))
      |-> ($past(hcnt) == HCNT_W'($past(hss))));

  // R13
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(line_end) |-> $stable(line_addr_o));

  // R13
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_end) |-> (line_addr_o == '0));

  // R6
  row_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (vcnt == '0));

  // R11
  lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && prot && (idx <= 8'd7)) |=> ($stable(htotal) && $stable(vtotal)));
endmodule

bind crt_timing_gen crt_timing_gen_chk #(
  .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hcnt(hcnt), .vcnt(vcnt),
  .line_end(line_end), .frame_end(frame_end), .hss(cfg.hss), .hpol(cfg.hpol),
  .htotal(cfg.htotal), .vtotal(cfg.vtotal), .data_we_i(data_we_i),
  .idx(idx), .prot(prot), .hsync_o(hsync_o), .line_addr_o(line_addr_o)
);

// File: tb/crt_timing_gen_bench.sv
module crt_timing_gen_bench;
  localparam int ADDR_W = 16;
  localparam int LIM    = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idx_we = 1'b0, data_we = 1'b0, misc_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic hsync, vsync, hblank, vblank, de;
  logic [ADDR_W-1:0] line_addr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crt_timing_gen #(.ADDR_W(ADDR_W)) u_crt_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(idx_we), .data_we_i(data_we),
    .misc_we_i(misc_we), .wdata_i(wdata), .rdata_o(rdata),
    .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank), .vblank_o(vblank),
    .de_o(de), .line_addr_o(line_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int k);
    case (k)
      0: return hsync;
      1: return vsync;
      2: return hblank;
      3: return vblank;
      4: return de;
      5: return ~hsync;
      default: return ~vsync;
    endcase
  endfunction

  task automatic measure(input int k, output int hi, output int per);
    int n = 0;
    while (sig(k) !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
    while (sig(k) !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    hi = 0;
    while (sig(k) === 1'b1 && n < LIM) begin @(negedge clk); hi++; n++; end
    per = hi;
    while (sig(k) === 1'b0 && n < LIM) begin @(negedge clk); per++; n++; end
  endtask

  task automatic count_high(input int k, input int len, output int c);
    c = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (sig(k) === 1'b1) c++;
    end
  endtask

  task automatic wr_idx(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; wdata = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    wr_idx(i);
    wr_dat(v);
  endtask

  task automatic wr_misc(input logic [7:0] v);
    @(negedge clk); misc_we = 1'b1; wdata = v;
    @(negedge clk); misc_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic base_cfg();
    wr_reg(8'h00, 8'd5);  wr_reg(8'h01, 8'd5);  wr_reg(8'h02, 8'd6);
    wr_reg(8'h03, 8'd8);  wr_reg(8'h04, 8'd7);  wr_reg(8'h05, 8'd9);
    wr_reg(8'h06, 8'd3);  wr_reg(8'h07, 8'h00); wr_reg(8'h09, 8'h01);
    wr_reg(8'h10, 8'd2);  wr_reg(8'h11, 8'h04); wr_reg(8'h12, 8'd1);
    wr_reg(8'h13, 8'd2);  wr_reg(8'h15, 8'd2);  wr_reg(8'h16, 8'd4);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 hsync", int'(hsync), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 blanks+de", int'(hblank | vblank | de), 0);
    chk("R1 line_addr", int'(line_addr), 0);
    chk("R1 rdata", int'(rdata), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    int hi, per, c;
    base_cfg();
    repeat (120) @(negedge clk);
    measure(0, hi, per);
    chk("R5 hsync width", hi, 2);
    chk("R2 line length", per, 10);
    measure(2, hi, per);
    chk("R4 hblank width", hi, 2);
    count_high(4, 50, c);
    chk("R3 de per frame", c, 12);
    measure(1, hi, per);
    chk("R7 vsync width", hi, 20);
    chk("R6 frame length", per, 50);
    measure(3, hi, per);
    chk("R8 vblank width", hi, 20);
  endtask

  task automatic t_addr();
    logic [ADDR_W-1:0] prev;
    int exp [5] = '{0, 16, 16, 32, 0};
    int n = 0;
    prev = line_addr;
    @(negedge clk);
    while (!(line_addr == 0 && prev != 0) && n < 500) begin
      prev = line_addr; @(negedge clk); n++;
    end
    chk("R13 wrap to 0", int'(line_addr), 0);
    for (int k = 0; k < 5; k++) begin
      repeat (10) @(negedge clk);
      chk("R13 line address", int'(line_addr), exp[k]);
    end
  endtask

  task automatic t_overflow();
    int hi, per, c;
    wr_reg(8'h07, 8'h01);
    measure(1, hi, per);
    measure(1, hi, per);
    chk("R6 vtotal bit8", per, 2610);
    wr_reg(8'h07, 8'h20);
    measure(1, hi, per);
    measure(1, hi, per);
    chk("R6 vtotal bit9", per, 5170);
    wr_reg(8'h07, 8'h04);
    repeat (6000) @(negedge clk);
    count_high(1, 200, c);
    chk("R7 vss bit8", c, 0);
    wr_reg(8'h07, 8'h80);
    repeat (120) @(negedge clk);
    count_high(1, 200, c);
    chk("R7 vss bit9", c, 0);
    wr_reg(8'h07, 8'h02);
    repeat (120) @(negedge clk);
    count_high(4, 50, c);
    chk("R9 vde bit8", c, 30);
    wr_reg(8'h07, 8'h40);
    repeat (120) @(negedge clk);
    count_high(4, 50, c);
    chk("R9 vde bit9", c, 30);
    wr_reg(8'h07, 8'h08);
    repeat (120) @(negedge clk);
    count_high(3, 200, c);
    chk("R8 vbs bit8", c, 0);
    wr_reg(8'h07, 8'h00);
    wr_reg(8'h09, 8'h21);
    repeat (120) @(negedge clk);
    count_high(3, 200, c);
    chk("R8 vbs bit9", c, 0);
    wr_reg(8'h09, 8'h01);
  endtask

  task automatic t_hbits();
    int hi, per;
    wr_reg(8'h00, 8'd60); wr_reg(8'h02, 8'd10); wr_reg(8'h03, 8'h02);
    wr_reg(8'h04, 8'd40); wr_reg(8'h05, 8'h8C);
    repeat (200) @(negedge clk);
    measure(2, hi, per);
    chk("R4 hblank 6-bit end", hi, 24);
    chk("R2 long line", per, 65);
    measure(0, hi, per);
    chk("R5 hsync 5-bit end", hi, 4);
    base_cfg();
  endtask

  task automatic t_pol();
    int hi, per;
    wr_misc(8'hC0);
    repeat (100) @(negedge clk);
    measure(5, hi, per);
    chk("R10 hsync active-low width", hi, 2);
    measure(6, hi, per);
    chk("R10 vsync active-low width", hi, 20);
    wr_misc(8'h00);
  endtask

  task automatic t_protect();
    int hi, per;
    logic [7:0] v;
    wr_reg(8'h11, 8'h84);
    wr_reg(8'h00, 8'd10);
    repeat (30) @(negedge clk);
    measure(0, hi, per);
    chk("R11 locked total unchanged", per, 10);
    rd_reg(8'h11, v);
    chk("R12 read lock reg", int'(v), 'h84);
    wr_dat(v & 8'h7F);
    wr_reg(8'h00, 8'd10);
    repeat (30) @(negedge clk);
    measure(0, hi, per);
    chk("R11 unlocked total", per, 15);
    rd_reg(8'h00, v);
    chk("R12 read total", int'(v), 10);
    rd_reg(8'h30, v);
    chk("R12 out of bank", int'(v), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_addr();
    t_overflow();
    t_hbits();
    t_pol();
    t_protect();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1-run actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule